// File: doc/BRIEF.md
# Gated Scaler Bank

The block is a bank of gated event counters that all listen to one shared increment line. The increment line is asynchronous to the system clock. It is sampled on the system clock, and every high-to-low transition produces one count in each counter whose gate is open at that moment. Each channel's gate opens when its bit in a control register is set, or when its own active-low external gate line is pulled low. The external gate lines are wired in reverse channel order. A per-channel status output shows which gates are open, so a driver of the gate lines can confirm that a channel is able to count.

A reset-and-load action closes the current counting interval. In one clock cycle it copies every running count, together with its overflow flag, into a holding register and restarts the counters. A bus write to the load address starts this action, and so does a rising edge on the external load strobe. Software then reads the held values at one bus address per channel while the counters keep running undisturbed.

Counters saturate at all ones. A sticky overflow flag records that an increment was lost because the counter was already at its limit.

Top module: `gated_scaler_bank`

## Requirements
- R1: Each high-to-low transition of `com_inc` advances every enabled counter by exactly one. A low-to-high transition, or a steady level, leaves every counter unchanged.
- R2: Channel c is enabled, and `gate_on[c]` is high, when its control gate bit is 1 or its external gate line is 0. A channel that is not enabled does not count.
- R3: Channel c (0-based) takes its external gate from `ext_gate_n[NUM_CH-1-c]`. Channel 0 uses the top line, and the last channel uses line 0.
- R4: Control register r is at bus address r and governs channels 4r to 4r+3. Bit 2j+1 is the gate bit of channel 4r+j. The even bits are stored and read back but do nothing. Writing 0xAA opens all four gates, and writing 0 closes them.
- R5: A bus write to address 64 copies each channel's count and overflow flag into its holding register and clears the counter and the flag, all in the same cycle.
- R6: A rising edge of `load_strobe` performs the same load as R5, exactly once for each assertion, however long the strobe stays high.
- R7: An increment edge that falls in the load cycle is not part of the held value. It is counted as 1 in the new interval.
- R8: Counters are CNT_W bits wide and stop at all ones. An increment at all ones sets the channel's overflow flag, and a load clears that flag.
- R9: A read of address 32+c returns the held count of channel c in bits [CNT_W-1:0] and the held overflow flag in bit 31. Reads of any address never change a running counter.
- R10: After reset, all counts, held values, overflow flags and control registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| com_inc | input | 1 | Shared increment line; counts on falling edges |
| ext_gate_n | input | NUM_CH | Active-low external gates, reverse channel order |
| load_strobe | input | 1 | Timing strobe; a rising edge triggers a load |
| gate_on | output | NUM_CH | Per-channel gate-open status |

## Verification
The bench drives one increment edge so that it lands in exactly the cycle of a bus load. A design that gives the edge to the old interval, or drops it, reads back a held value off by one. The bench holds the load strobe high across a further increment edge. A level-triggered load would clear that edge away, and a later load would then read zero instead of one. The bench drives a narrow counter past its limit and also stops it exactly at the limit. This separates a wrapping counter, a flag that sets too early, and a flag that survives the load. Finally, the bench opens a single external line at each end of the gate bus to expose a mapping that is not reversed.

// File: rtl/gsb_pkg.sv
`timescale 1ns/1ps
package gsb_pkg;
  localparam int SLOTS_PER_REG = 4;
  localparam int CTRL_W        = 8;

  // Channel c reads the external gate line from the opposite end of the bus.
  function automatic int ext_line(input int ch, input int n);
    return n - 1 - ch;
  endfunction

  // Bit inside a control register that opens the gate of slot j.
  function automatic int gate_pos(input int slot);
    return 2 * slot + 1;
  endfunction

  // Saturating increment, evaluated on a 32-bit container.
  function automatic logic [31:0] sat_next(input logic [31:0] v, input logic [31:0] top);
    return (v >= top) ? top : v + 32'd1;
  endfunction
endpackage

// File: rtl/gsb_sync.sv
`timescale 1ns/1ps
module gsb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gsb_edge_det.sv
`timescale 1ns/1ps
module gsb_edge_det #(
  parameter bit   FALLING = 1'b1,
  parameter logic IDLE    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_pulse
);
  logic lvl;
  logic prev;

  gsb_sync #(.W(1), .STAGES(2), .RST_VAL(IDLE)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(async_in), .sync_out(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_pulse = prev & ~lvl;
    end else begin : g_rise
      assign edge_pulse = ~prev & lvl;
    end
  endgenerate
endmodule

// File: rtl/gsb_ctrl_regs.sv
`timescale 1ns/1ps
module gsb_ctrl_regs
  import gsb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [CTRL_W-1:0]               wr_data,
  output logic [NUM_REGS-1:0][CTRL_W-1:0] regs_q,
  output logic [NUM_REGS*SLOTS_PER_REG-1:0] gate_bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (wr_addr == ADDR_W'(r)) regs_q[r] <= wr_data;
    end
  end

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      for (genvar j = 0; j < SLOTS_PER_REG; j++) begin : g_slot
        assign gate_bits[r*SLOTS_PER_REG + j] = regs_q[r][gate_pos(j)];
      end
    end
  endgenerate
endmodule

// File: rtl/gsb_channel.sv
`timescale 1ns/1ps
module gsb_channel
  import gsb_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q,
  output logic [CNT_W-1:0] held_q,
  output logic             held_ovf_q
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic             at_max;
  logic [CNT_W-1:0] cnt_nxt;

  assign at_max  = (cnt_q == MAXV);
  assign cnt_nxt = CNT_W'(sat_next(32'(cnt_q), 32'(MAXV)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      held_q     <= '0;
      held_ovf_q <= 1'b0;
    end else if (load) begin
      held_q     <= cnt_q;
      held_ovf_q <= ovf_q;
      cnt_q      <= inc ? CNT_W'(1) : '0;
      ovf_q      <= 1'b0;
    end else if (inc) begin
      cnt_q <= cnt_nxt;
      if (at_max) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/gated_scaler_bank.sv
`timescale 1ns/1ps
module gated_scaler_bank
  import gsb_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int CNT_W     = 24,
  parameter int ADDR_W    = 7,
  parameter int HOLD_BASE = 32,
  parameter int LOAD_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              com_inc,
  input  logic [NUM_CH-1:0] ext_gate_n,
  input  logic              load_strobe,
  output logic [NUM_CH-1:0] gate_on
);
  localparam int NUM_REGS = NUM_CH / SLOTS_PER_REG;

  // Named internal events, visible to the bound checker.
  logic                              com_fall;
  logic                              strobe_rise;
  logic                              bus_load;
  logic                              load_fire;
  logic [NUM_CH-1:0]                 inc_fire;
  logic [NUM_CH-1:0]                 ctrl_gate;
  logic [NUM_CH-1:0]                 ext_lvl;
  logic [NUM_REGS-1:0][CTRL_W-1:0]   regs_q;
  logic [NUM_CH-1:0][CNT_W-1:0]      cnt_q;
  logic [NUM_CH-1:0][CNT_W-1:0]      held_q;
  logic [NUM_CH-1:0]                 ovf_q;
  logic [NUM_CH-1:0]                 held_ovf_q;

  gsb_edge_det #(.FALLING(1'b1), .IDLE(1'b1)) com_det_i (
    .clk(clk), .rst_n(rst_n), .async_in(com_inc), .edge_pulse(com_fall)
  );

  gsb_edge_det #(.FALLING(1'b0), .IDLE(1'b0)) strobe_det_i (
    .clk(clk), .rst_n(rst_n), .async_in(load_strobe), .edge_pulse(strobe_rise)
  );

  gsb_sync #(.W(NUM_CH), .STAGES(2), .RST_VAL({NUM_CH{1'b1}})) ext_sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(ext_gate_n), .sync_out(ext_lvl)
  );

  gsb_ctrl_regs #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .regs_q(regs_q), .gate_bits(ctrl_gate)
  );

  assign bus_load  = bus_wr && (bus_addr == ADDR_W'(LOAD_ADDR));
  assign load_fire = bus_load | strobe_rise;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign gate_on[c]  = ctrl_gate[c] | ~ext_lvl[ext_line(c, NUM_CH)];
      assign inc_fire[c] = com_fall & gate_on[c];

      gsb_channel #(.CNT_W(CNT_W)) chan_i (
        .clk(clk), .rst_n(rst_n), .inc(inc_fire[c]), .load(load_fire),
        .cnt_q(cnt_q[c]), .ovf_q(ovf_q[c]),
        .held_q(held_q[c]), .held_ovf_q(held_ovf_q[c])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (bus_addr == ADDR_W'(r)) bus_rdata[CTRL_W-1:0] = regs_q[r];
    for (int c = 0; c < NUM_CH; c++)
      if (bus_addr == ADDR_W'(HOLD_BASE + c)) begin
        bus_rdata[CNT_W-1:0] = held_q[c];
        bus_rdata[31]        = held_ovf_q[c];
      end
  end
endmodule

// File: rtl/gsb_checker.sv
`timescale 1ns/1ps
module gsb_checker #(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 24
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         load_fire,
  input logic                         strobe_rise,
  input logic [NUM_CH-1:0]            inc_fire,
  input logic [NUM_CH-1:0]            ctrl_gate,
  input logic [NUM_CH-1:0]            gate_on,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] held_q,
  input logic [NUM_CH-1:0]            ovf_q
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  assert_single_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !strobe_rise);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_idle_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_fire && !inc_fire[c]) |=> $stable(cnt_q[c]));

      assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_fire && inc_fire[c] && cnt_q[c] != MAXV)
          |=> cnt_q[c] == CNT_W'($past(cnt_q[c]) + 1'b1));

      assert_ctrl_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_gate[c] |-> gate_on[c]);

      assert_load_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> held_q[c] == $past(cnt_q[c]));

      assert_coincide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> cnt_q[c] == CNT_W'($past(inc_fire[c])));

      assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_fire && cnt_q[c] == MAXV) |=> cnt_q[c] == MAXV);

      assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_fire && ovf_q[c]) |=> ovf_q[c]);

      assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> !ovf_q[c]);
    end
  endgenerate
endmodule

bind gated_scaler_bank gsb_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .strobe_rise(strobe_rise),
  .inc_fire(inc_fire), .ctrl_gate(ctrl_gate), .gate_on(gate_on),
  .cnt_q(cnt_q), .held_q(held_q), .ovf_q(ovf_q)
);

// File: tb/gated_scaler_bank_tb_top.sv
`timescale 1ns/1ps
module gated_scaler_bank_tb_top;
  localparam int NCH  = 32;
  localparam int CW   = 4;
  localparam int AW   = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          com_inc = 1'b1;
  logic [NCH-1:0] ext_gate_n = '1;
  logic          load_strobe = 1'b0;
  logic [NCH-1:0] gate_on;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gated_scaler_bank #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .com_inc(com_inc),
    .ext_gate_n(ext_gate_n), .load_strobe(load_strobe), .gate_on(gate_on)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); com_inc = 1'b0;
      repeat (3) @(negedge clk);
      com_inc = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic bus_load();
    wr(64, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_held(input int ch, input int cnt, input bit ovf, input string req);
    logic [31:0] d;
    rd(32 + ch, d);
    check(d == {ovf, 27'd0, 4'(cnt)}, req, d, {ovf, 27'd0, 4'(cnt)});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);   check(d == 0, "R10 ctrl reg", d, 0);
    rd(32, d);  check(d == 0, "R10 held ch0", d, 0);
    rd(63, d);  check(d == 0, "R10 held ch31", d, 0);
    check(gate_on == 0, "R10 gates closed", gate_on, 0);
  endtask

  task automatic t_ext_reverse();
    ext_gate_n = ~(32'h1 << 31);
    repeat (4) @(negedge clk);
    check(gate_on == 32'h1, "R3 top line opens ch0", gate_on, 32'h1);
    edges(3);
    bus_load();
    expect_held(0, 3, 0, "R1 ch0 counts falls once each");
    expect_held(31, 0, 0, "R2 closed ch31 ignores edges");
    ext_gate_n = ~32'h1;
    repeat (4) @(negedge clk);
    check(gate_on == 32'h8000_0000, "R3 line 0 opens ch31", gate_on, 32'h8000_0000);
    edges(2);
    bus_load();
    expect_held(31, 2, 0, "R3 ch31 counts via line 0");
    expect_held(0, 0, 0, "R5 ch0 cleared by previous load");
    ext_gate_n = '1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(1, 8'hAA);
    repeat (1) @(negedge clk);
    check(gate_on == 32'h0000_00F0, "R4 0xAA opens ch4..7", gate_on, 32'hF0);
    rd(1, d); check(d == 32'hAA, "R4 readback", d, 32'hAA);
    wr(1, 0);
    wr(2, 8'h08);
    @(negedge clk);
    check(gate_on == 32'h0000_0200, "R4 bit3 of reg2 opens ch9", gate_on, 32'h200);
    wr(2, 8'h55);
    @(negedge clk);
    check(gate_on == 0, "R4 even bits inert", gate_on, 0);
    rd(2, d); check(d == 32'h55, "R4 even bits stored", d, 32'h55);
    wr(2, 0);
  endtask

  task automatic t_strobe();
    wr(0, 8'h02);
    bus_load();
    edges(2);
    @(negedge clk); load_strobe = 1'b1;
    repeat (10) @(negedge clk);
    expect_held(0, 2, 0, "R6 strobe loads");
    edges(1);
    repeat (10) @(negedge clk);
    load_strobe = 1'b0;
    repeat (4) @(negedge clk);
    bus_load();
    expect_held(0, 1, 0, "R6 held strobe loads once");
  endtask

  task automatic t_coincide();
    bus_load();
    edges(2);
    @(negedge clk); com_inc = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = AW'(64); bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; com_inc = 1'b1;
    repeat (4) @(negedge clk);
    expect_held(0, 2, 0, "R7 coincident edge excluded from held");
    bus_load();
    expect_held(0, 1, 0, "R7 coincident edge in new interval");
  endtask

  task automatic t_saturate();
    bus_load();
    edges(15);
    bus_load();
    expect_held(0, 15, 0, "R8 exact limit no overflow");
    edges(17);
    bus_load();
    expect_held(0, 15, 1, "R8 saturate and flag");
    bus_load();
    expect_held(0, 0, 0, "R8 flag cleared by load");
  endtask

  task automatic t_reads();
    logic [31:0] d;
    bus_load();
    edges(2);
    for (int a = 0; a < 70; a++) rd(a, d);
    edges(2);
    rd(32, d); rd(64, d);
    bus_load();
    expect_held(0, 4, 0, "R9 reads leave counter intact");
    wr(0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ext_reverse();
    t_ctrl();
    t_strobe();
    t_coincide();
    t_saturate();
    t_reads();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule